// File: doc/BRIEF.md
# SPI Master with Selectable Clock Mode

This block is a single-master serial peripheral controller. It runs full-duplex frames with one slave. A host queues outgoing words in an eight-entry transmit queue. While the transmit queue holds words, the block drives the serial clock, the data-out line and an active-low select. On each frame it shifts one bit out and one bit in per clock period. Each completed frame leaves its received word in an eight-entry receive queue, where the host reads it.

Four inputs set the serial format. The clock polarity sets the idle level of the serial clock. The clock phase chooses whether data is sampled on the first or the second edge of each bit. The frame length runs from 4 to 16 bits. Two divider fields, a prescale value and a rate factor, set the serial bit period. Frames follow each other with no gap while words remain queued. The select line rises only after the last queued frame has completed. The host must hold the configuration steady while `busy` is high. It must also choose divider values that give at least eight system clocks per bit.

Top module: `spi_mode_master`

## Requirements
- R1: `ssN` goes low on the clock edge after which a queued word is taken for a frame. It stays low through every following frame. It rises on the final serial clock edge of a frame only when the transmit queue is empty at that edge.
- R2: While `ssN` is high, `sclk` rests at `cfgCpol`, following a change of `cfgCpol` one cycle later. Every frame starts and ends at that level.
- R3: With `h = max(1, floor(cfgPrescale/2))` and `s = cfgScr`, the serial clock changes level every `h*(s+1)` system clocks. The first change comes that many clocks after `ssN` falls. The lowest prescale bit is ignored, and prescale values 0 and 1 behave as 2.
- R4: A frame of N bits has exactly 2N serial clock edges. N is `cfgFrameLen` clamped to the range 4..16, so 0..3 give 4 and 17..31 give 16.
- R5: `mosi` sends bit N-1 of the queued word first, then the lower bits in order. Word bits above N-1 are not sent. With `cfgCpha`=0, the first bit is on `mosi` from the cycle `ssN` falls, and later bits change on even-numbered edges (2, 4, ...). With `cfgCpha`=1, bits change on odd-numbered edges (1, 3, ...). `mosi` never changes while `sclk` is steady within a frame.
- R6: `miso` is sampled at odd-numbered edges when `cfgCpha`=0 and at even-numbered edges when `cfgCpha`=1. The first sampled bit lands in bit N-1 of the received word and the last in bit 0. Bits above N-1 read zero.
- R7: When a frame ends and the transmit queue holds a word, the next frame starts on the same edge. `ssN` stays low, and its first serial edge comes one half period later.
- R8: The transmit queue holds 8 words. `txNotFull` is low while it holds 8, and a `txPush` made while it is full has no effect.
- R9: The receive queue holds 8 words. The received word is written on a frame's final edge and is dropped if the queue is full. `rxWord` shows the oldest word while `rxNotEmpty` is high, and `rxPop` removes it.
- R10: `busy` is high while a frame is in progress or the transmit queue is not empty. Whenever `busy` is low, `ssN` is high.
- R11: During reset, `ssN`=1, `busy`=0, `txNotFull`=1 and `rxNotEmpty`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfgCpol | input | 1 | Idle level of the serial clock |
| cfgCpha | input | 1 | 0: sample on first edge of each bit, 1: on second edge |
| cfgFrameLen | input | 5 | Bits per frame, clamped to 4..16 |
| cfgPrescale | input | 8 | Even prescale divisor (bit 0 ignored) |
| cfgScr | input | 8 | Rate factor; the divisor is multiplied by this plus one |
| txWord | input | 16 | Word to queue; low N bits are sent |
| txPush | input | 1 | Queue `txWord` this cycle |
| txNotFull | output | 1 | Transmit queue has room |
| rxWord | output | 16 | Oldest received word |
| rxPop | input | 1 | Remove the oldest received word |
| rxNotEmpty | output | 1 | Receive queue holds a word |
| busy | output | 1 | Frame in progress or words queued |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 1 | Slave select, active low |

## Verification
A pushed word is counted in the queue after the edge that accepts it. `ssN` falls and the first data bit appears on the next edge. Each serial edge then follows every `h*(s+1)` clocks. The received word and `rxNotEmpty` update on the same system edge as a frame's last serial edge. A behavioural model built from queues and integer counters advances on every rising clock edge with the same inputs, including a pseudo-random `miso` stream. Every output is compared against it at the following falling edge, so each result is checked in the exact cycle it is due. Directed checks add edge counts per frame for the length clamp and a pop count after a receive overflow.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

  typedef enum logic {ST_IDLE, ST_XFER} xferState_t;

  // Per-cycle strobes from the sequencer to the shifter
  typedef struct packed {
    logic park;    // hold the serial clock at its idle level
    logic load;    // take the next queued word into the shifter
    logic toggle;  // flip the serial clock
    logic sample;  // capture the data-in line (shift)
    logic launch;  // present the next data-out bit
    logic done;    // last edge of the frame
  } xferStrobes_t;

endpackage

// File: rtl/spi_mm_fifo.sv
module spi_mm_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic             doWrite, doRead;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign doWrite = push && !full;
  assign doRead  = pop && !empty;
  assign rdData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWrite) wrPtr <= wrPtr + AW'(1);
      if (doRead)  rdPtr <= rdPtr + AW'(1);
      if (doWrite && !doRead)      count <= count + (AW+1)'(1);
      else if (doRead && !doWrite) count <= count - (AW+1)'(1);
    end
  end
endmodule

// File: rtl/spi_mm_ctrl.sv
module spi_mm_ctrl
  import spi_mm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5,
  parameter int PRE_W  = 8,
  parameter int SCR_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgCpha,
  input  logic [PRE_W-1:0] cfgPrescale,
  input  logic [SCR_W-1:0] cfgScr,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             txHasData,
  output xferStrobes_t     strobes,
  output logic             ssN,
  output logic             busy
);
  localparam int SLOT_W = $clog2(2*DATA_W + 1);

  xferState_t        state;
  logic [PRE_W-1:0]  preCnt, preHalf;
  logic [SCR_W-1:0]  scrCnt;
  logic [SLOT_W-1:0] slot, slotNext;
  logic              preWrap, halfTick, lastSlot, inXfer;

  // Half of the even prescale value; 0 and 1 act as 2
  always_comb begin
    preHalf = cfgPrescale >> 1;
    if (preHalf == '0) preHalf = PRE_W'(1);
  end

  assign inXfer   = (state == ST_XFER);
  assign preWrap  = (preCnt == preHalf - PRE_W'(1));
  assign halfTick = inXfer && preWrap && (scrCnt == cfgScr);
  assign slotNext = slot + SLOT_W'(1);
  assign lastSlot = halfTick && (slotNext == SLOT_W'({frameLen, 1'b0}));

  always_comb begin
    strobes.park   = !inXfer;
    strobes.load   = txHasData && (!inXfer || lastSlot);
    strobes.toggle = halfTick;
    // odd edge numbers sample when phase is 0, even when phase is 1
    strobes.sample = halfTick && (slotNext[0] != cfgCpha);
    strobes.launch = halfTick && (slotNext[0] == cfgCpha);
    strobes.done   = lastSlot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      preCnt <= '0;
      scrCnt <= '0;
      slot   <= '0;
    end else if (!inXfer) begin
      preCnt <= '0;
      scrCnt <= '0;
      slot   <= '0;
      if (txHasData) state <= ST_XFER;
    end else begin
      if (preWrap) begin
        preCnt <= '0;
        scrCnt <= (scrCnt == cfgScr) ? '0 : scrCnt + SCR_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
      if (halfTick) slot <= lastSlot ? '0 : slotNext;
      if (lastSlot && !txHasData) state <= ST_IDLE;
    end
  end

  assign ssN  = !inXfer;
  assign busy = inXfer || txHasData;
endmodule

// File: rtl/spi_mm_datapath.sv
module spi_mm_datapath
  import spi_mm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xferStrobes_t      strobes,
  input  logic              cfgCpol,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [DATA_W-1:0] txWord,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rxWord
);
  logic [DATA_W-1:0] shiftReg, nextShift, aligned, lenMask;
  logic [LEN_W-1:0]  padBits;

  // Move the frame's top bit to the shifter MSB
  assign padBits   = LEN_W'(DATA_W) - frameLen;
  assign aligned   = txWord << padBits;
  assign lenMask   = ~({DATA_W{1'b1}} << frameLen);
  assign nextShift = strobes.sample ? {shiftReg[DATA_W-2:0], miso} : shiftReg;
  assign rxWord    = nextShift & lenMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      shiftReg <= '0;
    end else begin
      if (strobes.park)        sclk <= cfgCpol;
      else if (strobes.toggle) sclk <= ~sclk;

      if (strobes.load) begin
        shiftReg <= aligned;
        mosi     <= aligned[DATA_W-1];
      end else begin
        if (strobes.sample) shiftReg <= nextShift;
        if (strobes.launch) mosi     <= shiftReg[DATA_W-1];
      end
    end
  end
endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
  import spi_mm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MIN_LEN = 4,
  parameter int DEPTH   = 8,
  parameter int PRE_W   = 8,
  parameter int SCR_W   = 8,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic [LEN_W-1:0]  cfgFrameLen,
  input  logic [PRE_W-1:0]  cfgPrescale,
  input  logic [SCR_W-1:0]  cfgScr,
  input  logic [DATA_W-1:0] txWord,
  input  logic              txPush,
  output logic              txNotFull,
  output logic [DATA_W-1:0] rxWord,
  input  logic              rxPop,
  output logic              rxNotEmpty,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ssN
);
  xferStrobes_t      strobes;
  logic [LEN_W-1:0]  effLen;
  logic [DATA_W-1:0] txHead, rxFrame;
  logic              txEmpty, txFull, rxEmpty, rxFull;

  always_comb begin
    if (cfgFrameLen < LEN_W'(MIN_LEN))     effLen = LEN_W'(MIN_LEN);
    else if (cfgFrameLen > LEN_W'(DATA_W)) effLen = LEN_W'(DATA_W);
    else                                   effLen = cfgFrameLen;
  end

  spi_mm_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) txFifo (
    .clk(clk), .rst_n(rst_n), .push(txPush), .wrData(txWord),
    .pop(strobes.load), .rdData(txHead), .empty(txEmpty), .full(txFull));

  spi_mm_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) rxFifo (
    .clk(clk), .rst_n(rst_n), .push(strobes.done), .wrData(rxFrame),
    .pop(rxPop), .rdData(rxWord), .empty(rxEmpty), .full(rxFull));

  spi_mm_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W), .PRE_W(PRE_W), .SCR_W(SCR_W)) ctrl (
    .clk(clk), .rst_n(rst_n), .cfgCpha(cfgCpha), .cfgPrescale(cfgPrescale),
    .cfgScr(cfgScr), .frameLen(effLen), .txHasData(!txEmpty),
    .strobes(strobes), .ssN(ssN), .busy(busy));

  spi_mm_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dpath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .cfgCpol(cfgCpol),
    .frameLen(effLen), .txWord(txHead), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rxWord(rxFrame));

  assign txNotFull  = !txFull;
  assign rxNotEmpty = !rxEmpty;
  // full flag of the receive queue only gates its own writes
  logic unusedRxFull;
  assign unusedRxFull = rxFull;
endmodule

// File: rtl/spi_mode_master_chk.sv
module spi_mode_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cfgCpol,
  input logic txPush,
  input logic busy,
  input logic sclk,
  input logic mosi,
  input logic ssN
);
  // R2
  sclk_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ssN && $past(ssN) && $past(rst_n) && $stable(cfgCpol)) |-> (sclk == cfgCpol));

  // R2
  frame_start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ssN) && $stable(cfgCpol)) |-> (sclk == cfgCpol));

  // R10
  idle_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ssN);

  // R1
  select_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ssN) && !$past(txPush)) |-> !busy);

  // R5
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ssN && !$past(ssN) && $stable(sclk)) |-> $stable(mosi));
endmodule

bind spi_mode_master spi_mode_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfgCpol(cfgCpol), .txPush(txPush),
  .busy(busy), .sclk(sclk), .mosi(mosi), .ssN(ssN));

// File: tb/tb_spi_mode_master.sv
`timescale 1ns/1ps
module tb_spi_mode_master;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cfgCpol, cfgCpha, txPush, rxPop, miso;
  logic [4:0]  cfgFrameLen;
  logic [7:0]  cfgPrescale, cfgScr;
  logic [15:0] txWord, rxWord;
  logic        txNotFull, rxNotEmpty, busy, sclk, mosi, ssN;

  spi_mode_master dut (
    .clk(clk), .rst_n(rst_n), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgFrameLen(cfgFrameLen), .cfgPrescale(cfgPrescale), .cfgScr(cfgScr),
    .txWord(txWord), .txPush(txPush), .txNotFull(txNotFull), .rxWord(rxWord),
    .rxPop(rxPop), .rxNotEmpty(rxNotEmpty), .busy(busy), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ssN(ssN));

  int nChecks = 0, nFails = 0, cyc = 0, toggles = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] wordGen = 16'h3C5A;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int txq[$], rxq[$];
  bit mActive = 0, live = 0;
  int mSlot, mDiv, mCur, mAcc;
  logic mSclk = 1'b0, mMosi = 1'b0;

  function automatic int lenOf(input logic [4:0] v);
    if (v < 4) return 4;
    if (v > 16) return 16;
    return int'(v);
  endfunction

  always @(posedge clk) begin
    int L, h, H, bitI, rxVal;
    bit txFullB, rxFullB, gotRx;
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      mActive = 0; live = 0; mSclk = 1'b0; mMosi = 1'b0;
    end else begin
      L = lenOf(cfgFrameLen);
      h = int'(cfgPrescale) / 2;
      if (h == 0) h = 1;
      H = h * (int'(cfgScr) + 1);
      txFullB = (txq.size() == 8);
      rxFullB = (rxq.size() == 8);
      gotRx = 0; rxVal = 0;
      if (!mActive) begin
        mSclk = cfgCpol;
        if (txq.size() > 0) begin
          mCur = txq.pop_front(); mActive = 1; mDiv = 0; mSlot = 0; mAcc = 0;
          mMosi = mCur[L-1];
        end
      end else begin
        mDiv++;
        if (mDiv == H) begin
          mDiv = 0; mSlot++; mSclk = !mSclk;
          bitI = (mSlot - 1) / 2;
          if (((mSlot % 2) == 1) == (cfgCpha == 1'b0)) mAcc = (mAcc << 1) | int'(miso);
          else if (cfgCpha == 1'b0) begin
            if (bitI + 1 < L) mMosi = mCur[L-2-bitI];
          end else mMosi = mCur[L-1-bitI];
          if (mSlot == 2*L) begin
            gotRx = 1; rxVal = mAcc;
            if (txq.size() > 0) begin
              mCur = txq.pop_front(); mDiv = 0; mSlot = 0; mAcc = 0;
              mMosi = mCur[L-1];
            end else mActive = 0;
          end
        end
      end
      if (rxPop && rxq.size() > 0) void'(rxq.pop_front());
      if (gotRx && !rxFullB) rxq.push_back(rxVal);
      if (txPush && !txFullB) txq.push_back(int'(txWord));
      live = 1;
    end
  end

  // ---------------- per-cycle comparison ----------------
  logic prevSclk = 1'b0, prevSsN = 1'b1;
  always @(negedge clk) begin
    if (rst_n && live) begin
      check(ssN == !mActive, "R1 R7 ssN", ssN, !mActive);
      if (!mActive) check(sclk == mSclk, "R2 sclk idle", sclk, mSclk);
      else          check(sclk == mSclk, "R3 R4 sclk timing", sclk, mSclk);
      if (!ssN) check(mosi == mMosi, "R5 mosi", mosi, mMosi);
      check(busy == (mActive || txq.size() > 0), "R10 busy", busy, (mActive || txq.size() > 0));
      check(txNotFull == (txq.size() < 8), "R8 txNotFull", txNotFull, (txq.size() < 8));
      check(rxNotEmpty == (rxq.size() > 0), "R9 rxNotEmpty", rxNotEmpty, (rxq.size() > 0));
      if (rxq.size() > 0) check(rxWord == 16'(rxq[0]), "R6 rxWord", rxWord, rxq[0]);
      if (sclk != prevSclk && !prevSsN) toggles++;
      prevSclk = sclk;
      prevSsN  = ssN;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso = lfsr[0];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "watchdog expired R1", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic setCfg(input logic pol, input logic pha, input logic [4:0] len,
                        input logic [7:0] pre, input logic [7:0] scr);
    @(negedge clk);
    cfgCpol = pol; cfgCpha = pha; cfgFrameLen = len; cfgPrescale = pre; cfgScr = scr;
    @(negedge clk);
  endtask

  task automatic pushBurst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wordGen = {wordGen[14:0], wordGen[15] ^ wordGen[11]} ^ 16'(i * 7);
      txWord = wordGen; txPush = 1'b1;
    end
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain(output int pops);
    pops = 0;
    while (rxNotEmpty) begin
      rxPop = 1'b1;
      @(negedge clk);
      rxPop = 1'b0;
      pops++;
    end
  endtask

  task automatic runCase(input logic pol, input logic pha, input logic [4:0] len,
                         input logic [7:0] pre, input logic [7:0] scr, input int n);
    int pops;
    setCfg(pol, pha, len, pre, scr);
    pushBurst(n);
    waitIdle();
    drain(pops);
    check(pops == n, "R9 received count", pops, n);
  endtask

  initial begin
    int pops;
    rst_n = 1'b0; txPush = 1'b0; rxPop = 1'b0; txWord = '0; miso = 1'b0;
    cfgCpol = 1'b0; cfgCpha = 1'b0; cfgFrameLen = 5'd8; cfgPrescale = 8'd2; cfgScr = 8'd3;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(ssN == 1'b1,       "R11 ssN in reset", ssN, 1);
    check(busy == 1'b0,      "R11 busy in reset", busy, 0);
    check(txNotFull == 1'b1, "R11 txNotFull in reset", txNotFull, 1);
    check(rxNotEmpty == 1'b0,"R11 rxNotEmpty in reset", rxNotEmpty, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    runCase(1'b0, 1'b0, 5'd8,  8'd2, 8'd3, 3);   // mode 0, back-to-back (R7)
    runCase(1'b0, 1'b1, 5'd4,  8'd4, 8'd3, 2);   // mode 1
    runCase(1'b1, 1'b0, 5'd16, 8'd6, 8'd1, 2);   // mode 2
    runCase(1'b1, 1'b1, 5'd12, 8'd2, 8'd5, 2);   // mode 3
    runCase(1'b0, 1'b0, 5'd5,  8'd5, 8'd1, 2);   // odd prescale (R3)
    runCase(1'b1, 1'b1, 5'd6,  8'd0, 8'd7, 2);   // zero prescale (R3)

    // R4 clamp below range: two frames of 4 bits
    setCfg(1'b0, 1'b1, 5'd3, 8'd2, 8'd3);
    toggles = 0;
    pushBurst(2); waitIdle(); drain(pops);
    check(toggles == 16, "R4 edges for clamped short frames", toggles, 16);

    // R4 clamp above range: one frame of 16 bits
    setCfg(1'b1, 1'b0, 5'd31, 8'd2, 8'd3);
    toggles = 0;
    pushBurst(1); waitIdle(); drain(pops);
    check(toggles == 32, "R4 edges for clamped long frame", toggles, 32);

    // R8 / R9 overflow: 11 pushes, 9 accepted, 8 kept
    setCfg(1'b0, 1'b0, 5'd4, 8'd2, 8'd3);
    pushBurst(11); waitIdle(); drain(pops);
    check(pops == 8, "R9 receive overflow keeps 8", pops, 8);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule